// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a segment-and-offset logical address into a linear address. It works in two modes, chosen for each request. In real mode, a 16-bit segment is multiplied by sixteen and added to a 16-bit offset. The sum wraps inside a 1 MB space. In protected mode, the selector picks a descriptor from one of two small on-chip tables, a global one and a local one. The descriptor's base is added to a 32-bit offset. The offset is checked against the descriptor's limit, and the descriptor's present flag is checked too.

Each request is a one-cycle strobe carrying the mode, the selector or segment, and the offset. One cycle later the unit answers with either a valid strobe and the linear address, or a fault strobe. A write port loads descriptors into the tables. Paging and fetching descriptors from memory are outside this block.

A small state machine sequences the answer. It has three states:
- ST_IDLE: no answer is being given.
- ST_VALID: the address is good and is shown.
- ST_FAULT: the request was refused.

Every state takes the same transitions:
- If no request is present, it goes to ST_IDLE.
- A real-mode request goes to ST_VALID.
- A protected-mode request that passes every check goes to ST_VALID.
- A protected-mode request that fails any check goes to ST_FAULT.

Top module: `seg_xlate_top`

## Requirements
- R1: With `mode`=0, `lin_addr` = (sel×16 + offset[15:0]) mod 2^20, with bits 31:20 zero and `fault` low.
- R2: Real-mode pairs that name the same location give the same `lin_addr`. For example, 0000:01F0, 0001:01E0 and 0010:00F0 all give 001F0. Likewise, 08F1:0100 gives 09010 and 028F:0030 gives 02920.
- R3: With `mode`=1 and all checks passing, `lin_addr` = (descriptor base + offset) mod 2^32.
- R4: In protected mode, selector bit 2 picks the table (0 = global, 1 = local). The entry index is sel[15:3]. Bits 1:0 have no effect.
- R5: In protected mode, an offset greater than the descriptor limit faults. An offset equal to the limit does not fault.
- R6: A descriptor whose access field has bit 7 (present) clear faults.
- R7: A global selector with index 0 (the null selector) faults. So does any index of 8 or more.
- R8: `valid` or `fault` is raised exactly one cycle after `req`, for one cycle. The two are never high together, and neither is high without a request in the cycle before.
- R9: Synchronous reset clears `valid` and `fault`, and marks every descriptor as not present.
- R10: While `fault` is high, `lin_addr` is zero.
- R11: A descriptor write (`wr_en`) into table `wr_local`, entry `wr_idx`, is used by requests issued in the cycles after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Translation request strobe |
| mode | input | 1 | 0 = real mode, 1 = protected mode |
| sel | input | 16 | Segment (real) or selector (protected) |
| offset | input | 32 | Offset; only bits 15:0 are used in real mode |
| lin_addr | output | 32 | Linear address result |
| valid | output | 1 | Result-good strobe |
| fault | output | 1 | Translation refused strobe |
| wr_en | input | 1 | Descriptor write enable |
| wr_local | input | 1 | Write target: 0 = global table, 1 = local table |
| wr_idx | input | 3 | Entry written |
| wr_base | input | 32 | Descriptor base |
| wr_limit | input | 32 | Descriptor limit, byte granular |
| wr_access | input | 8 | Access field; bit 7 is the present flag |

## Verification
The assertions assume that `req` and `mode` are clean levels sampled at the clock edge. They also assume that a descriptor write never targets the entry being translated in the same cycle. The stimulus keeps to this by applying every input on the falling edge. Table writes and requests are never issued together. Real-mode stimulus sweeps segment and offset across the whole 16-bit range on a coarse grid, including the wrapping corner. Protected-mode stimulus walks every table, entry and low-selector-bit value, using offsets at zero, at the limit and just past it.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int SEG_W      = 16;
    localparam int OFF_W      = 32;
    localparam int REAL_W     = 20;
    localparam int ACC_W      = 8;
    localparam int PRESENT_BIT = 7;

    typedef struct packed {
        logic [OFF_W-1:0] base;
        logic [OFF_W-1:0] limit;
        logic [ACC_W-1:0] acc;
    } desc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VALID,
        ST_FAULT
    } xl_state_t;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlate_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_local,
    input  logic [IDX_W-1:0] wr_idx,
    input  desc_t            wr_desc,
    input  logic             rd_local,
    input  logic [IDX_W-1:0] rd_idx,
    output desc_t            rd_desc
);
    desc_t tbl_rd [2];

    for (genvar t = 0; t < 2; t++) begin : g_tbl
        desc_t mem [ENTRIES];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
            end else if (wr_en && (wr_local == t[0])) begin
                mem[wr_idx] <= wr_desc;
            end
        end
        assign tbl_rd[t] = mem[rd_idx];
    end

    assign rd_desc = rd_local ? tbl_rd[1] : tbl_rd[0];
endmodule

// File: rtl/seg_real_calc.sv
module seg_real_calc
    import seg_xlate_pkg::*;
(
    input  logic [SEG_W-1:0] seg,
    input  logic [SEG_W-1:0] ofs,
    output logic [OFF_W-1:0] lin
);
    logic [REAL_W-1:0] sum;
    always_comb begin
        sum = {seg, 4'b0000} + {{(REAL_W-SEG_W){1'b0}}, ofs};
        lin = {{(OFF_W-REAL_W){1'b0}}, sum};
    end
endmodule

// File: rtl/seg_prot_check.sv
module seg_prot_check
    import seg_xlate_pkg::*;
(
    input  desc_t            desc,
    input  logic [OFF_W-1:0] ofs,
    input  logic             in_range,
    input  logic             is_null,
    output logic [OFF_W-1:0] lin,
    output logic             flt
);
    always_comb begin
        flt = !in_range || is_null || !desc.acc[PRESENT_BIT] || (ofs > desc.limit);
        lin = desc.base + ofs;
    end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int HI_W   = SEG_W - 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             mode,
    input  logic [15:0]      sel,
    input  logic [31:0]      offset,
    output logic [31:0]      lin_addr,
    output logic             valid,
    output logic             fault,
    input  logic             wr_en,
    input  logic             wr_local,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_base,
    input  logic [31:0]      wr_limit,
    input  logic [7:0]       wr_access
);
    xl_state_t         state, nxt;
    desc_t             rd_desc, wr_desc;
    logic [HI_W-1:0]   sel_hi;
    logic              in_range, is_null, p_flt;
    logic [OFF_W-1:0]  p_lin, r_lin, addr_q;

    assign sel_hi   = sel[SEG_W-1:3];
    assign in_range = sel_hi < HI_W'(ENTRIES);
    assign is_null  = !sel[2] && (sel_hi == '0);
    assign wr_desc  = '{base: wr_base, limit: wr_limit, acc: wr_access};

    seg_desc_table #(.ENTRIES(ENTRIES)) i_tbl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_local (wr_local),
        .wr_idx   (wr_idx),
        .wr_desc  (wr_desc),
        .rd_local (sel[2]),
        .rd_idx   (sel_hi[IDX_W-1:0]),
        .rd_desc  (rd_desc)
    );

    seg_real_calc i_real (
        .seg (sel),
        .ofs (offset[SEG_W-1:0]),
        .lin (r_lin)
    );

    seg_prot_check i_prot (
        .desc     (rd_desc),
        .ofs      (offset),
        .in_range (in_range),
        .is_null  (is_null),
        .lin      (p_lin),
        .flt      (p_flt)
    );

    always_comb begin
        nxt = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_VALID, ST_FAULT: begin
                if (!req)                nxt = ST_IDLE;
                else if (mode && p_flt)  nxt = ST_FAULT;
                else                     nxt = ST_VALID;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
        end else begin
            state <= nxt;
            if (req) addr_q <= !mode ? r_lin : (p_flt ? '0 : p_lin);
        end
    end

    always_comb begin
        valid    = (state == ST_VALID);
        fault    = (state == ST_FAULT);
        lin_addr = fault ? '0 : addr_q;
    end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req,
    input logic        mode,
    input logic [15:0] sel,
    input logic [31:0] lin_addr,
    input logic        valid,
    input logic        fault
);
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(valid && fault));
    p_answer_r8: assert property (@(posedge clk) disable iff (rst)
        req |=> (valid || fault));
    p_cause_r8: assert property (@(posedge clk) disable iff (rst)
        (valid || fault) |-> $past(req));
    p_real_hi_r1: assert property (@(posedge clk) disable iff (rst)
        (req && !mode) |=> (valid && lin_addr[31:20] == 12'h000));
    p_fault_zero_r10: assert property (@(posedge clk) disable iff (rst)
        fault |-> (lin_addr == 32'h0));
    p_null_r7: assert property (@(posedge clk) disable iff (rst)
        (req && mode && sel[15:2] == 14'h0) |=> fault);
endmodule

bind seg_xlate_top seg_xlate_chk i_chk (.*);

// File: tb/test_seg_xlate_top.sv
module test_seg_xlate_top;
    logic        clk = 0, rst = 1, req = 0, mode = 0;
    logic [15:0] sel = 0;
    logic [31:0] offset = 0;
    logic [31:0] lin_addr;
    logic        valid, fault;
    logic        wr_en = 0, wr_local = 0;
    logic [2:0]  wr_idx = 0;
    logic [31:0] wr_base = 0, wr_limit = 0;
    logic [7:0]  wr_access = 0;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [31:0] m_base [2][8];
    logic [31:0] m_lim  [2][8];
    logic        m_pres [2][8];

    always #2.5 clk = ~clk;

    seg_xlate_top i_seg_xlate_top (.*);

    task automatic chk(string tag, logic ev, logic ef, logic [31:0] ea);
        checks++;
        if (valid !== ev || fault !== ef || lin_addr !== ea) begin
            errors++;
            $display("FAIL %s: got v=%0b f=%0b a=%h, expected v=%0b f=%0b a=%h",
                     tag, valid, fault, lin_addr, ev, ef, ea);
        end
    endtask

    task automatic xlate(logic m, logic [15:0] s, logic [31:0] o);
        @(negedge clk);
        req = 1; mode = m; sel = s; offset = o;
        @(negedge clk);
        req = 0;
    endtask

    task automatic wr(logic loc, int idx, logic [31:0] b, logic [31:0] l, logic p);
        @(negedge clk);
        wr_en = 1; wr_local = loc; wr_idx = 3'(idx);
        wr_base = b; wr_limit = l; wr_access = {p, 7'h13};
        m_base[loc][idx] = b; m_lim[loc][idx] = l; m_pres[loc][idx] = p;
        @(negedge clk);
        wr_en = 0;
    endtask

    function automatic logic [31:0] real_exp(logic [15:0] s, logic [15:0] o);
        return (32'(s) * 16 + 32'(o)) % 32'h100000;
    endfunction

    task automatic real_chk(string tag, logic [15:0] s, logic [15:0] o);
        xlate(0, s, {16'hABCD, o});
        chk(tag, 1, 0, real_exp(s, o));
    endtask

    task automatic prot_chk(string tag, logic [15:0] s, logic [31:0] o);
        int t, idx;
        logic f;
        t = int'(s[2]);
        idx = int'(s[15:3]);
        f = (idx >= 8) || (t == 0 && idx == 0);
        if (!f) f = !m_pres[t][idx] || (o > m_lim[t][idx]);
        xlate(1, s, o);
        chk(tag, !f, f, f ? 32'h0 : m_base[t][idx] + o);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 8; i++) begin
                m_base[t][i] = 0; m_lim[t][i] = 0; m_pres[t][i] = 0;
            end
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R9 reset", 0, 0, 32'h0);
        // R9: descriptors not present after reset
        prot_chk("R9 local after reset", 16'h000C, 32'h0);
        prot_chk("R9 global after reset", 16'h0008, 32'h0);

        // R2 aliases and worked examples
        real_chk("R2 alias a", 16'h0000, 16'h01F0);
        real_chk("R2 alias b", 16'h0001, 16'h01E0);
        real_chk("R2 alias c", 16'h0010, 16'h00F0);
        xlate(0, 16'h08F1, 32'h0100); chk("R2 08F1:0100", 1, 0, 32'h09010);
        xlate(0, 16'h028F, 32'h0030); chk("R2 028F:0030", 1, 0, 32'h02920);
        // R1 wrap corner
        xlate(0, 16'hFFFF, 32'hFFFF_FFFF); chk("R1 wrap", 1, 0, 32'h0FFEF);

        // R1 sweep
        for (int s = 0; s <= 16'hFFFF; s += 16'h0F0F)
            for (int o = 0; o <= 16'hFFFF; o += 16'h0F0F)
                real_chk("R1 sweep", 16'(s), 16'(o));

        // R11 load descriptors
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 8; i++)
                wr(t[0], i, 32'(t * 8 + i) * 32'h2345_6789,
                   32'h100 * 32'(i + 1) + 32'(t), i != 5);

        // R3 R4 R5 R6 R7 sweep: every table, entry, low bits, offsets at and past limit
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 8; i++)
                for (int r = 0; r < 4; r++) begin
                    logic [15:0] s;
                    s = 16'(i * 8 + t * 4 + r);
                    prot_chk("R3 R4 base zero", s, 32'h0);
                    prot_chk("R5 at limit", s, m_lim[t][i]);
                    prot_chk("R5 past limit", s, m_lim[t][i] + 1);
                end

        // R7 index out of range
        prot_chk("R7 index 8 global", 16'h0040, 32'h0);
        prot_chk("R7 index high local", 16'hFFFC, 32'h0);
        // R3 wrap of base plus offset, R11 overwrite
        wr(1, 7, 32'hFFFF_FF00, 32'hFFFF_FFFF, 1);
        prot_chk("R3 wrap R11", 16'h003C, 32'h0000_0200);
        // R6 present cleared by rewrite
        wr(0, 3, 32'h1234_0000, 32'hFFFF, 0);
        prot_chk("R6 not present", 16'h0018, 32'h10);

        // R8 back-to-back requests, and no answer without request
        @(negedge clk);
        req = 1; mode = 0; sel = 16'h1000; offset = 32'h1;
        @(negedge clk);
        chk("R8 first", 1, 0, 32'h10001);
        sel = 16'h0000; mode = 1; offset = 0;
        @(negedge clk);
        req = 0;
        chk("R8 second fault", 0, 1, 32'h0);
        @(negedge clk);
        checks++;
        if (valid !== 0 || fault !== 0) begin
            errors++;
            $display("FAIL R8 idle: got v=%0b f=%0b, expected v=0 f=0", valid, fault);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule